// File: doc/BRIEF.md
# Three-Line Byte Handshake Controller

This block sits on the controller side of a byte-wide serial link to a host processor. The host and the controller pace each byte with three active-low lines that share one 8-bit port register. The host drives a frame-active line and an acknowledge line. The controller drives a request line. Every byte moves through one 8-bit shift register. Bytes the host sends are gathered into a small outbound buffer. Bytes the controller has queued for the host are handed out of a larger inbound buffer, one per handshake step.

The host writes the port register, the control register and the shift register through plain write strobes. Neither clock edges nor bit clocks pace a byte: a change of the host's handshake levels does. The block raises a shift event flag after every byte step, at every frame end and at every idle synchronisation step. When a host frame closes with data in it, the block emits a one-cycle packet-done pulse together with the byte count. The surrounding logic then reads the gathered bytes through a read port. To queue a reply, it writes the bytes into the inbound buffer and pulses a load strobe with the length.

Top module: `shift_link_handshake`

## Requirements
- R1: After reset the request line reads inactive (port read bit 3 = 1), the event flag is 0, packet-done is 0, packet length is 0 and the shift register reads 0.
- R2: The port register uses bit 5 for frame-active and bit 4 for acknowledge, and port read bit 3 shows the request line; all three are active low. Control register bit 4 set to 1 means the host sends and 0 means the controller sends. The handshake is evaluated in the cycle after a write to the port or control register, so its effects become visible after the second clock edge.
- R3: While frame-active is low and the host sends, each change of the frame-active/acknowledge pair stores the shift register into the next outbound slot and sets the flag. Once OUT_DEPTH bytes are held, a further step stores nothing and leaves the flag unset.
- R4: While frame-active is low and the controller sends, each change of the pair loads the next unread inbound byte into the shift register and sets the flag. With no unread byte, a step changes neither the shift register nor the flag.
- R5: The step that takes the last queued inbound byte drives request inactive (high).
- R6: While frame-active is high and was high at the previous evaluation, a change of acknowledge makes request take the acknowledge level and sets the flag.
- R7: When frame-active goes high after being low, the flag is set. If at least one outbound byte was gathered, packet-done pulses for one cycle with packet length equal to the byte count. The count then returns to zero. An empty frame gives no pulse.
- R8: Whenever frame-active is high and the synchronisation rule does not apply, unread inbound bytes drive request active (low).
- R9: A load strobe sets the inbound length, returns the read position to the first byte, sets the flag and triggers a handshake evaluation.
- R10: The flag clear input clears the event flag at the next edge.
- R11: The outbound read port returns the gathered bytes in arrival order, slot 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pb_we | input | 1 | Port register write strobe |
| pb_wdata | input | 8 | Port register write data |
| pb_rdata | output | 8 | Port register read value, request on bit 3 |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| sr_we | input | 1 | Shift register write strobe |
| sr_wdata | input | 8 | Shift register write data |
| sr_rdata | output | 8 | Shift register value |
| sflag | output | 1 | Shift event flag |
| sflag_clr | input | 1 | Clear the shift event flag |
| in_we | input | 1 | Inbound buffer byte write |
| in_waddr | input | $clog2(IN_DEPTH) | Inbound buffer write slot |
| in_wdata | input | 8 | Inbound buffer write byte |
| in_load | input | 1 | Queue an inbound packet |
| in_load_len | input | $clog2(IN_DEPTH+1) | Length of the queued packet |
| out_raddr | input | $clog2(OUT_DEPTH) | Outbound buffer read slot |
| out_rdata | output | 8 | Outbound buffer byte at out_raddr |
| pkt_done | output | 1 | One-cycle pulse at the end of a non-empty host frame |
| pkt_len | output | $clog2(OUT_DEPTH+1) | Byte count of the last completed host frame |

## Verification
The bench builds the block with OUT_DEPTH=4 and IN_DEPTH=8. With these values the outbound buffer fills after four host steps, so the ignored fifth step and a frame end with a full count can be observed in a few dozen cycles. A short inbound packet lets the run reach the last-byte release of request, steps with no bytes left, and a reload in the middle of a frame. The bench also covers the idle synchronisation toggles and an empty frame end, both of which touch only the request line and the flag.

// File: rtl/shl_pkg.sv
package shl_pkg;

  localparam int unsigned BIT_REQ = 3;
  localparam int unsigned BIT_ACK = 4;
  localparam int unsigned BIT_TIP = 5;
  localparam int unsigned BIT_DIR = 4;

  typedef struct packed {
    logic store;
    logic take;
    logic release_req;
    logic sync;
    logic frame_end;
    logic req_assert;
    logic flag;
  } hs_act_t;

  function automatic logic hs_toggled(logic [1:0] cur, logic [1:0] prev);
    return cur != prev;
  endfunction

  function automatic logic last_step(int unsigned idx, int unsigned len);
    return (idx + 1) >= len;
  endfunction

  function automatic logic next_req(logic cur, logic rel, logic sync,
                                    logic ack_lvl, logic drive_low);
    if (rel)            return 1'b1;
    else if (sync)      return ack_lvl;
    else if (drive_low) return 1'b0;
    return cur;
  endfunction

  function automatic logic [7:0] merge_req(logic [7:0] b, logic r);
    logic [7:0] v;
    v = b;
    v[BIT_REQ] = r;
    return v;
  endfunction

endpackage

// File: rtl/shl_decide.sv
module shl_decide
  import shl_pkg::*;
(
  input  logic    eval,
  input  logic    tip_n,
  input  logic    ack_n,
  input  logic    last_tip_n,
  input  logic    last_ack_n,
  input  logic    host_sends,
  input  logic    out_full,
  input  logic    in_unread,
  input  logic    in_last,
  output hs_act_t act
);

  logic pair_changed;
  assign pair_changed = hs_toggled({tip_n, ack_n}, {last_tip_n, last_ack_n});

  always_comb begin
    act = '0;
    if (eval) begin
      if (!tip_n) begin
        if (host_sends) begin
          if (pair_changed && !out_full) begin
            act.store = 1'b1;
            act.flag  = 1'b1;
          end
        end else if (pair_changed && in_unread) begin
          act.take        = 1'b1;
          act.flag        = 1'b1;
          act.release_req = in_last;
        end
      end else if (last_tip_n && (ack_n != last_ack_n)) begin
        act.sync = 1'b1;
        act.flag = 1'b1;
      end else begin
        if (!last_tip_n) begin
          act.frame_end = 1'b1;
          act.flag      = 1'b1;
        end
        act.req_assert = in_unread;
      end
    end
  end

endmodule

// File: rtl/shl_out_buf.sv
module shl_out_buf #(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       store,
  input  logic [7:0]                 sbyte,
  input  logic                       clear,
  input  logic [$clog2(DEPTH)-1:0]   raddr,
  output logic [7:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       full
);

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];

  assign full  = (cnt == CW'(DEPTH));
  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (store) mem[cnt[AW-1:0]] <= sbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (store)  cnt <= cnt + CW'(1);
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_store_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> cnt == $past(cnt) + CW'(1));
  p_clear_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0);

endmodule

// File: rtl/shl_in_buf.sv
module shl_in_buf
  import shl_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(DEPTH)-1:0]   waddr,
  input  logic [7:0]                 wdata,
  input  logic                       load,
  input  logic [$clog2(DEPTH+1)-1:0] load_len,
  input  logic                       take,
  output logic                       unread,
  output logic                       is_last,
  output logic [7:0]                 cur_byte
);

  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] idx;
  logic [LW-1:0] len;

  assign unread   = idx < len;
  assign is_last  = last_step(32'(idx), 32'(len));
  assign cur_byte = unread ? mem[idx[AW-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      len <= '0;
    end else if (load) begin
      idx <= '0;
      len <= load_len;
    end else if (take && unread) begin
      idx <= idx + LW'(1);
    end
  end

  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= len);
  p_load_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == '0) && (len == $past(load_len)));

endmodule

// File: rtl/shift_link_handshake.sv
module shift_link_handshake
  import shl_pkg::*;
#(
  parameter int unsigned OUT_DEPTH = 16,
  parameter int unsigned IN_DEPTH  = 128
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           pb_we,
  input  logic [7:0]                     pb_wdata,
  output logic [7:0]                     pb_rdata,
  input  logic                           ctl_we,
  input  logic [7:0]                     ctl_wdata,
  output logic [7:0]                     ctl_rdata,
  input  logic                           sr_we,
  input  logic [7:0]                     sr_wdata,
  output logic [7:0]                     sr_rdata,
  output logic                           sflag,
  input  logic                           sflag_clr,
  input  logic                           in_we,
  input  logic [$clog2(IN_DEPTH)-1:0]    in_waddr,
  input  logic [7:0]                     in_wdata,
  input  logic                           in_load,
  input  logic [$clog2(IN_DEPTH+1)-1:0]  in_load_len,
  input  logic [$clog2(OUT_DEPTH)-1:0]   out_raddr,
  output logic [7:0]                     out_rdata,
  output logic                           pkt_done,
  output logic [$clog2(OUT_DEPTH+1)-1:0] pkt_len
);

  localparam int unsigned OCW = $clog2(OUT_DEPTH + 1);

  logic [7:0]     pb_q;
  logic [7:0]     ctl_q;
  logic [7:0]     sr_q;
  logic [1:0]     last_hs;
  logic           eval_q;
  logic           req_n;
  hs_act_t        act;
  logic           out_full;
  logic [OCW-1:0] out_cnt;
  logic           in_unread;
  logic           in_last;
  logic [7:0]     in_byte;
  logic           flag_set;
  logic           done_now;

  assign pb_rdata  = merge_req(pb_q, req_n);
  assign ctl_rdata = ctl_q;
  assign sr_rdata  = sr_q;
  assign flag_set  = act.flag | in_load;
  assign done_now  = act.frame_end && (out_cnt != '0);

  shl_decide u_decide (
    .eval       (eval_q),
    .tip_n      (pb_q[BIT_TIP]),
    .ack_n      (pb_q[BIT_ACK]),
    .last_tip_n (last_hs[1]),
    .last_ack_n (last_hs[0]),
    .host_sends (ctl_q[BIT_DIR]),
    .out_full   (out_full),
    .in_unread  (in_unread),
    .in_last    (in_last),
    .act        (act)
  );

  shl_out_buf #(.DEPTH(OUT_DEPTH)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .store (act.store),
    .sbyte (sr_q),
    .clear (act.frame_end),
    .raddr (out_raddr),
    .rdata (out_rdata),
    .cnt   (out_cnt),
    .full  (out_full)
  );

  shl_in_buf #(.DEPTH(IN_DEPTH)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (in_we),
    .waddr    (in_waddr),
    .wdata    (in_wdata),
    .load     (in_load),
    .load_len (in_load_len),
    .take     (act.take),
    .unread   (in_unread),
    .is_last  (in_last),
    .cur_byte (in_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_q     <= 8'h30;
      ctl_q    <= '0;
      sr_q     <= '0;
      last_hs  <= 2'b11;
      eval_q   <= 1'b0;
      req_n    <= 1'b1;
      sflag    <= 1'b0;
      pkt_done <= 1'b0;
      pkt_len  <= '0;
    end else begin
      if (pb_we)  pb_q  <= pb_wdata;
      if (ctl_we) ctl_q <= ctl_wdata;
      last_hs <= {pb_q[BIT_TIP], pb_q[BIT_ACK]};
      eval_q  <= pb_we | ctl_we | in_load;
      if (act.take)   sr_q <= in_byte;
      else if (sr_we) sr_q <= sr_wdata;
      req_n <= next_req(req_n, act.release_req, act.sync,
                        pb_q[BIT_ACK], act.req_assert);
      if (flag_set)       sflag <= 1'b1;
      else if (sflag_clr) sflag <= 1'b0;
      pkt_done <= done_now;
      if (done_now) pkt_len <= out_cnt;
    end
  end

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> sflag);
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act.release_req |=> req_n);
  p_sync_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act.sync |=> req_n == $past(pb_q[BIT_ACK]));
  p_done_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> pkt_len != '0);
  p_take_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act.take |=> sr_q == $past(in_byte));
  p_idle_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act.req_assert && !act.sync) |=> !req_n);

endmodule

// File: tb/test_shift_link_handshake.sv
module test_shift_link_handshake;

  localparam int unsigned OD = 4;
  localparam int unsigned ID = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pb_we = 0, ctl_we = 0, sr_we = 0, sflag_clr = 0, in_we = 0, in_load = 0;
  logic [7:0] pb_wdata = 0, ctl_wdata = 0, sr_wdata = 0, in_wdata = 0;
  logic [$clog2(ID)-1:0]   in_waddr = 0;
  logic [$clog2(ID+1)-1:0] in_load_len = 0;
  logic [$clog2(OD)-1:0]   out_raddr = 0;
  logic [7:0] pb_rdata, ctl_rdata, sr_rdata, out_rdata;
  logic sflag, pkt_done;
  logic [$clog2(OD+1)-1:0] pkt_len;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shift_link_handshake #(.OUT_DEPTH(OD), .IN_DEPTH(ID)) i_shift_link_handshake (
    .clk(clk), .rst_n(rst_n),
    .pb_we(pb_we), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .sflag(sflag), .sflag_clr(sflag_clr),
    .in_we(in_we), .in_waddr(in_waddr), .in_wdata(in_wdata),
    .in_load(in_load), .in_load_len(in_load_len),
    .out_raddr(out_raddr), .out_rdata(out_rdata),
    .pkt_done(pkt_done), .pkt_len(pkt_len)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_pb(logic [7:0] v);
    pb_we = 1; pb_wdata = v; step(); pb_we = 0; step();
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; step(); ctl_we = 0; step();
  endtask

  task automatic wr_sr(logic [7:0] v);
    sr_we = 1; sr_wdata = v; step(); sr_we = 0;
  endtask

  task automatic clr_flag();
    sflag_clr = 1; step(); sflag_clr = 0;
  endtask

  task automatic load_pkt(logic [7:0] base, int n);
    for (int i = 0; i < n; i++) begin
      in_we = 1; in_waddr = i[$clog2(ID)-1:0]; in_wdata = base + 8'(i); step();
    end
    in_we = 0;
    in_load = 1; in_load_len = n[$clog2(ID+1)-1:0]; step(); in_load = 0; step();
  endtask

  task automatic t_reset();
    check("R1 request idle", 32'(pb_rdata[3]), 1);
    check("R1 flag", 32'(sflag), 0);
    check("R1 pkt_done", 32'(pkt_done), 0);
    check("R1 pkt_len", 32'(pkt_len), 0);
    check("R1 shift reg", 32'(sr_rdata), 0);
  endtask

  task automatic t_host_send();
    wr_ctl(8'h10);
    check("R2 ctl readback", 32'(ctl_rdata), 32'h10);
    clr_flag();
    check("R10 flag cleared", 32'(sflag), 0);
    wr_sr(8'hA0);
    pb_we = 1; pb_wdata = 8'h10; step(); pb_we = 0;
    check("R2 no effect after first edge", 32'(sflag), 0);
    step();
    check("R2 effect after second edge", 32'(sflag), 1);
    wr_sr(8'hA1); wr_pb(8'h00);
    wr_sr(8'hA2); wr_pb(8'h10);
    wr_sr(8'hA3); wr_pb(8'h00);
    clr_flag();
    wr_sr(8'hA4); wr_pb(8'h10);
    check("R3 full step sets no flag", 32'(sflag), 0);
    wr_pb(8'h30);
    check("R7 frame end flag", 32'(sflag), 1);
    check("R7 pkt_done pulse", 32'(pkt_done), 1);
    check("R7 pkt_len", 32'(pkt_len), 4);
    step();
    check("R7 pkt_done one cycle", 32'(pkt_done), 0);
    for (int i = 0; i < 4; i++) begin
      out_raddr = i[$clog2(OD)-1:0]; #1;
      check("R11 R3 outbound slot", 32'(out_rdata), 32'hA0 + 32'(i));
    end
  endtask

  task automatic t_empty_frame();
    wr_ctl(8'h00);
    clr_flag();
    wr_pb(8'h10);
    check("R4 step with nothing queued", 32'(sflag), 0);
    wr_pb(8'h30);
    check("R7 empty frame flag", 32'(sflag), 1);
    check("R7 empty frame no pulse", 32'(pkt_done), 0);
  endtask

  task automatic t_ctrl_send();
    clr_flag();
    load_pkt(8'hB0, 3);
    check("R9 load sets flag", 32'(sflag), 1);
    check("R8 request active with bytes", 32'(pb_rdata[3]), 0);
    wr_pb(8'h10);
    check("R4 first byte", 32'(sr_rdata), 32'hB0);
    check("R5 request held low", 32'(pb_rdata[3]), 0);
    wr_pb(8'h00);
    check("R4 second byte", 32'(sr_rdata), 32'hB1);
    wr_pb(8'h10);
    check("R4 third byte", 32'(sr_rdata), 32'hB2);
    check("R5 request released", 32'(pb_rdata[3]), 1);
    clr_flag();
    wr_pb(8'h00);
    check("R4 exhausted keeps shift reg", 32'(sr_rdata), 32'hB2);
    check("R4 exhausted no flag", 32'(sflag), 0);
    wr_pb(8'h20);
    check("R7 frame end after send", 32'(sflag), 1);
    check("R7 no pulse after send", 32'(pkt_done), 0);
    check("R8 request stays idle", 32'(pb_rdata[3]), 1);
  endtask

  task automatic t_sync();
    wr_pb(8'h30);
    check("R6 request follows ack high", 32'(pb_rdata[3]), 1);
    clr_flag();
    wr_pb(8'h20);
    check("R6 request follows ack low", 32'(pb_rdata[3]), 0);
    check("R6 sync sets flag", 32'(sflag), 1);
    wr_pb(8'h30);
    check("R6 request back high", 32'(pb_rdata[3]), 1);
  endtask

  task automatic t_reload();
    load_pkt(8'hC0, 2);
    check("R8 request active after load", 32'(pb_rdata[3]), 0);
    wr_pb(8'h10);
    check("R4 took first byte", 32'(sr_rdata), 32'hC0);
    clr_flag();
    load_pkt(8'hD0, 3);
    check("R9 reload flag", 32'(sflag), 1);
    check("R9 reload no take", 32'(sr_rdata), 32'hC0);
    wr_pb(8'h00);
    check("R9 read position rewound", 32'(sr_rdata), 32'hD0);
    wr_pb(8'h10);
    check("R9 next after rewind", 32'(sr_rdata), 32'hD1);
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_host_send();
    t_empty_frame();
    t_ctrl_send();
    t_sync();
    t_reload();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule